// File: doc/BRIEF.md
# Readout Protection Level Controller

This block holds the device life-cycle protection level as an 8-bit option byte and turns it into one of three levels: open (0), protected (1) and closed (2). Software asks to change the byte through a single-cycle write strobe. The controller applies the write only when the move between levels is allowed. Upgrades (open to protected, open or protected to closed) go one way only. Downgrades are gated by two independent lock flags and two 128-bit passwords. A debug port presents a password while the device is held in its reset phase.

The level drives the policy outputs: whether debug is enabled, whether debug may reach memories, and which boot source is used. A downgrade from protected to open first raises a mass-erase request. It waits for an erase-done handshake before the byte becomes the open code. A downgrade from closed to protected erases nothing. The option byte is a register that reset loads with the parameter `OB_INIT`.

The control FSM has three states. **IDLE** accepts writes and password injections. **KEY_EVAL** compares a captured password for one cycle. **ERASE** holds the erase request until the erase completes.

The transitions are:
- IDLE→KEY_EVAL on a valid injection during the reset phase.
- IDLE→ERASE on a software write of 0xAA at level 1 with the level-1 lock clear.
- KEY_EVAL→IDLE on a level-2 grant (the byte becomes `PROT_CODE`) or on a failure (the error flag is set).
- KEY_EVAL→ERASE on a level-1 grant.
- ERASE→IDLE on erase-done (the byte becomes 0xAA).

Top module: `prot_level_ctrl`

## Requirements
- R1: The level output is 0 when the option byte is 0xAA, 2 when it is 0xCC, and 1 for any other value. After reset the byte is `OB_INIT` (default 0xAA).
- R2: At level 0 a write stores the written byte: 0xCC gives level 2, 0xAA stays at level 0, and any other value gives level 1. The new value is visible the cycle after the write strobe.
- R3: At level 1 a write of 0xCC gives level 2. A write of any value other than 0xAA or 0xCC is stored and keeps level 1.
- R4: At level 2 every software write is ignored and the option byte keeps its value.
- R5: At level 2, with the level-2 lock set, an injection that uses selector 1 and carries a key equal to the level-2 password sets the byte to `PROT_CODE` (default 0x55). This happens two cycles after the injection strobe. No erase request is raised.
- R6: A password injection that is not granted leaves the byte unchanged and sets the sticky error flag two cycles after the strobe. A grant needs a matching key, the selected lock set, and the level the selector targets: selector 0 for level 1, selector 1 for level 2.
- R7: At level 1, with the level-1 lock set, an injection that uses selector 0 and carries a key equal to the level-1 password enters the erase phase two cycles after the strobe. Injections made while the reset-phase input is low are ignored.
- R8: At level 1 a write of 0xAA starts the erase phase when the level-1 lock is clear. The write is ignored when the lock is set.
- R9: In the erase phase, erase_req and busy stay high until erase_done. The byte becomes 0xAA the cycle after erase_done. Writes and injections during the phase are ignored, and erase_done outside the phase has no effect.
- R10: dbg_mem_en is high only at level 0. dbg_en is low at level 2.
- R11: At level 2 boot_sel is 0 (user flash) whatever boot_mode is. At levels 0 and 1, boot_sel follows boot_mode (0 flash, 1 system memory, 2 SRAM), and 3 maps to 0.
- R12: At level 1, dbg_en is high when boot_lock is low or dbg_swen is high, and low otherwise. At level 0, dbg_en is high.
- R13: The error flag stays set until err_clr is pulsed. It reads 0 the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_req | input | 1 | Software option-byte write strobe |
| wr_data | input | 8 | Byte to write |
| err_clr | input | 1 | Write-1 clear of the key error flag |
| rst_phase | input | 1 | Device held in reset phase (debug injection window) |
| key_inj_valid | input | 1 | Debug password injection strobe |
| key_inj_sel | input | 1 | 0: level-1 password, 1: level-2 password |
| key_inj_data | input | 128 | Injected password |
| oem1_lock | input | 1 | Level 1→0 password lock flag |
| oem2_lock | input | 1 | Level 2→1 password lock flag |
| oem1_key | input | 128 | Provisioned level-1 password |
| oem2_key | input | 128 | Provisioned level-2 password |
| boot_lock | input | 1 | Boot-lock flag |
| dbg_swen | input | 1 | Software debug-enable bit |
| boot_mode | input | 2 | Boot-mode configuration |
| erase_done | input | 1 | Mass erase complete |
| ob_value | output | 8 | Current option byte |
| level | output | 2 | Decoded protection level |
| busy | output | 1 | FSM not in IDLE |
| erase_req | output | 1 | Mass erase request |
| key_err | output | 1 | Sticky password failure flag |
| dbg_en | output | 1 | Debug port enabled |
| dbg_mem_en | output | 1 | Debug may access flash, SRAM and backup registers |
| boot_sel | output | 2 | Selected boot source |

## Verification
On every cycle the assertions check the following:
- the byte is frozen at level 2 apart from the password path;
- level 0 is never reached from level 2 in one step;
- level 0 is reached from level 1 only straight after an erase handshake;
- the erase request is held until it is acknowledged;
- the error flag is sticky and is set only by a key evaluation;
- the closed-level debug and boot restrictions hold.

Only the directed scenarios show the rest:
- the exact byte values each transition produces;
- the two-cycle password latency;
- grants and refusals for each lock setting;
- that writes and injections are ignored while busy or outside the reset phase.

// File: rtl/prot_lvl_pkg.sv
package prot_lvl_pkg;
    typedef enum logic [1:0] {
        LVL_OPEN   = 2'd0,
        LVL_PROT   = 2'd1,
        LVL_CLOSED = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_KEY_EVAL = 2'd1,
        ST_ERASE    = 2'd2
    } fsm_e;

    localparam logic [1:0] BOOT_FLASH  = 2'd0;
    localparam logic [1:0] BOOT_SYSMEM = 2'd1;
    localparam logic [1:0] BOOT_SRAM   = 2'd2;
endpackage

// File: rtl/prot_level_decode.sv
module prot_level_decode
    import prot_lvl_pkg::*;
#(
    parameter int          OB_W        = 8,
    parameter logic [OB_W-1:0] OPEN_CODE   = 8'hAA,
    parameter logic [OB_W-1:0] CLOSED_CODE = 8'hCC
) (
    input  logic [OB_W-1:0] code,
    output lvl_e            lvl
);
    always_comb begin
        if (code == OPEN_CODE)
            lvl = LVL_OPEN;
        else if (code == CLOSED_CODE)
            lvl = LVL_CLOSED;
        else
            lvl = LVL_PROT;
    end
endmodule

// File: rtl/prot_key_check.sv
module prot_key_check #(
    parameter int KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             sel_in,
    input  logic [KEY_W-1:0] key_in,
    input  logic [KEY_W-1:0] key1_ref,
    input  logic [KEY_W-1:0] key2_ref,
    output logic             sel_q,
    output logic             match
);
    logic [KEY_W-1:0] key_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
            sel_q <= 1'b0;
        end else if (capture) begin
            key_q <= key_in;
            sel_q <= sel_in;
        end
    end

    assign match = (key_q == (sel_q ? key2_ref : key1_ref));
endmodule

// File: rtl/prot_access_policy.sv
module prot_access_policy
    import prot_lvl_pkg::*;
(
    input  lvl_e       lvl,
    input  logic       boot_lock,
    input  logic       dbg_swen,
    input  logic [1:0] boot_mode,
    output logic       dbg_en,
    output logic       dbg_mem_en,
    output logic [1:0] boot_sel
);
    logic [1:0] cfg_boot;

    always_comb begin
        unique case (boot_mode)
            2'd1:    cfg_boot = BOOT_SYSMEM;
            2'd2:    cfg_boot = BOOT_SRAM;
            default: cfg_boot = BOOT_FLASH;
        endcase
    end

    always_comb begin
        dbg_en     = 1'b0;
        dbg_mem_en = 1'b0;
        boot_sel   = cfg_boot;
        unique case (lvl)
            LVL_OPEN: begin
                dbg_en     = 1'b1;
                dbg_mem_en = 1'b1;
            end
            LVL_PROT: begin
                dbg_en = !boot_lock || dbg_swen;
            end
            default: begin
                boot_sel = BOOT_FLASH;
            end
        endcase
    end
endmodule

// File: rtl/prot_level_ctrl.sv
module prot_level_ctrl
    import prot_lvl_pkg::*;
#(
    parameter int          OB_W      = 8,
    parameter int          KEY_W     = 128,
    parameter logic [7:0]  OB_INIT   = 8'hAA,
    parameter logic [7:0]  PROT_CODE = 8'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [OB_W-1:0]  wr_data,
    input  logic             err_clr,
    input  logic             rst_phase,
    input  logic             key_inj_valid,
    input  logic             key_inj_sel,
    input  logic [KEY_W-1:0] key_inj_data,
    input  logic             oem1_lock,
    input  logic             oem2_lock,
    input  logic [KEY_W-1:0] oem1_key,
    input  logic [KEY_W-1:0] oem2_key,
    input  logic             boot_lock,
    input  logic             dbg_swen,
    input  logic [1:0]       boot_mode,
    input  logic             erase_done,
    output logic [OB_W-1:0]  ob_value,
    output logic [1:0]       level,
    output logic             busy,
    output logic             erase_req,
    output logic             key_err,
    output logic             dbg_en,
    output logic             dbg_mem_en,
    output logic [1:0]       boot_sel
);
    localparam logic [OB_W-1:0] OPEN_CODE   = OB_W'(8'hAA);
    localparam logic [OB_W-1:0] CLOSED_CODE = OB_W'(8'hCC);

    fsm_e            state, state_nx;
    logic [OB_W-1:0] ob_q, ob_nx;
    logic            err_set;
    logic            key_start;
    logic            key_sel_q;
    logic            key_match;
    logic            grant_l2, grant_l1;
    lvl_e            lvl;

    prot_level_decode #(
        .OB_W(OB_W), .OPEN_CODE(OPEN_CODE), .CLOSED_CODE(CLOSED_CODE)
    ) u_decode (
        .code (ob_q),
        .lvl  (lvl)
    );

    assign key_start = (state == ST_IDLE) && key_inj_valid && rst_phase;

    prot_key_check #(.KEY_W(KEY_W)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (key_start),
        .sel_in   (key_inj_sel),
        .key_in   (key_inj_data),
        .key1_ref (oem1_key),
        .key2_ref (oem2_key),
        .sel_q    (key_sel_q),
        .match    (key_match)
    );

    prot_access_policy u_policy (
        .lvl        (lvl),
        .boot_lock  (boot_lock),
        .dbg_swen   (dbg_swen),
        .boot_mode  (boot_mode),
        .dbg_en     (dbg_en),
        .dbg_mem_en (dbg_mem_en),
        .boot_sel   (boot_sel)
    );

    assign grant_l2 = key_sel_q  && (lvl == LVL_CLOSED) && oem2_lock && key_match;
    assign grant_l1 = !key_sel_q && (lvl == LVL_PROT)   && oem1_lock && key_match;

    // Next-state and option-byte update
    always_comb begin
        state_nx = state;
        ob_nx    = ob_q;
        err_set  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (key_start) begin
                    state_nx = ST_KEY_EVAL;
                end else if (wr_req) begin
                    unique case (lvl)
                        LVL_OPEN: ob_nx = wr_data;
                        LVL_PROT: begin
                            if (wr_data == CLOSED_CODE)
                                ob_nx = CLOSED_CODE;
                            else if (wr_data == OPEN_CODE) begin
                                if (!oem1_lock)
                                    state_nx = ST_ERASE;
                            end else
                                ob_nx = wr_data;
                        end
                        default: ob_nx = ob_q;
                    endcase
                end
            end
            ST_KEY_EVAL: begin
                state_nx = ST_IDLE;
                if (grant_l2)
                    ob_nx = PROT_CODE;
                else if (grant_l1)
                    state_nx = ST_ERASE;
                else
                    err_set = 1'b1;
            end
            ST_ERASE: begin
                if (erase_done) begin
                    ob_nx    = OPEN_CODE;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Option byte and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob_q    <= OB_INIT;
            key_err <= 1'b0;
        end else begin
            ob_q <= ob_nx;
            if (err_set)
                key_err <= 1'b1;
            else if (err_clr)
                key_err <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        ob_value  = ob_q;
        level     = lvl;
        busy      = (state != ST_IDLE);
        erase_req = (state == ST_ERASE);
    end

    AST_CLOSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && lvl == LVL_CLOSED) |=> $stable(ob_q)) // R4
        else $error("closed byte changed");
    AST_NO_SKIP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lvl) == LVL_CLOSED) |-> (lvl != LVL_OPEN)) // R5
        else $error("closed went straight to open");
    AST_ERASE_BEFORE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lvl) == LVL_PROT && lvl == LVL_OPEN) |-> $past(erase_req && erase_done)) // R7
        else $error("open reached without erase");
    AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done) |=> (erase_req && busy)) // R9
        else $error("erase request dropped");
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_err) |-> $past(state == ST_KEY_EVAL)) // R6
        else $error("error set outside key evaluation");
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (key_err && !err_clr) |=> key_err) // R13
        else $error("error flag lost");
    AST_CLOSED_NO_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 2'd2) |-> (!dbg_en && !dbg_mem_en)) // R10
        else $error("debug open at level 2");
    AST_CLOSED_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 2'd2) |-> (boot_sel == BOOT_FLASH)) // R11
        else $error("boot not forced at level 2");
endmodule

// File: tb/tb_prot_level_ctrl.sv
`timescale 1ns/1ps
module tb_prot_level_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_req = 1'b0;
    logic [7:0]   wr_data = '0;
    logic         err_clr = 1'b0;
    logic         rst_phase = 1'b0;
    logic         key_inj_valid = 1'b0;
    logic         key_inj_sel = 1'b0;
    logic [127:0] key_inj_data = '0;
    logic         oem1_lock = 1'b0;
    logic         oem2_lock = 1'b0;
    logic [127:0] oem1_key = 128'h0123_4567_89AB_CDEF_1122_3344_5566_7788;
    logic [127:0] oem2_key = 128'hFEDC_BA98_7654_3210_A5A5_5A5A_0F0F_F0F0;
    logic         boot_lock = 1'b0;
    logic         dbg_swen = 1'b0;
    logic [1:0]   boot_mode = 2'd0;
    logic         erase_done = 1'b0;
    logic [7:0]   ob_value;
    logic [1:0]   level, boot_sel;
    logic         busy, erase_req, key_err, dbg_en, dbg_mem_en;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    prot_level_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .err_clr(err_clr), .rst_phase(rst_phase), .key_inj_valid(key_inj_valid),
        .key_inj_sel(key_inj_sel), .key_inj_data(key_inj_data),
        .oem1_lock(oem1_lock), .oem2_lock(oem2_lock), .oem1_key(oem1_key),
        .oem2_key(oem2_key), .boot_lock(boot_lock), .dbg_swen(dbg_swen),
        .boot_mode(boot_mode), .erase_done(erase_done), .ob_value(ob_value),
        .level(level), .busy(busy), .erase_req(erase_req), .key_err(key_err),
        .dbg_en(dbg_en), .dbg_mem_en(dbg_mem_en), .boot_sel(boot_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic sw_write(input logic [7:0] d);
        wr_req = 1'b1;
        wr_data = d;
        tick();
        wr_req = 1'b0;
    endtask

    task automatic inject(input logic sel, input logic [127:0] k, input logic phase);
        rst_phase = phase;
        key_inj_valid = 1'b1;
        key_inj_sel = sel;
        key_inj_data = k;
        tick();
        key_inj_valid = 1'b0;
        rst_phase = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset byte", ob_value, 8'hAA);
        check("R1 reset level", level, 2'd0);
        check("R9 reset busy", busy, 1'b0);
        check("R9 reset erase_req", erase_req, 1'b0);
        check("R13 reset key_err", key_err, 1'b0);
        check("R10 open dbg_mem_en", dbg_mem_en, 1'b1);
        check("R12 open dbg_en", dbg_en, 1'b1);
    endtask

    task automatic t_open_writes();
        sw_write(8'hAA);
        check("R2 open write AA", level, 2'd0);
        sw_write(8'h5A);
        check("R2 open write other byte", ob_value, 8'h5A);
        check("R1 other byte level", level, 2'd1);
        check("R10 prot dbg_mem_en", dbg_mem_en, 1'b0);
        check("R12 prot no bootlock", dbg_en, 1'b1);
        boot_lock = 1'b1;
        #1 check("R12 prot bootlock", dbg_en, 1'b0);
        dbg_swen = 1'b1;
        #1 check("R12 prot bootlock swen", dbg_en, 1'b1);
        boot_lock = 1'b0; dbg_swen = 1'b0;
        boot_mode = 2'd1;
        #1 check("R11 prot sysmem", boot_sel, 2'd1);
        boot_mode = 2'd3;
        #1 check("R11 mode 3 maps flash", boot_sel, 2'd0);
        sw_write(8'h17);
        check("R3 prot rewrite", ob_value, 8'h17);
        sw_write(8'hCC);
        check("R3 prot to closed", level, 2'd2);
        boot_mode = 2'd2;
        #1 check("R11 closed forces flash", boot_sel, 2'd0);
        check("R10 closed dbg_en", dbg_en, 1'b0);
    endtask

    task automatic t_closed_locked();
        sw_write(8'hAA);
        check("R4 closed write AA", ob_value, 8'hCC);
        sw_write(8'h11);
        check("R4 closed write other", ob_value, 8'hCC);
    endtask

    task automatic t_key2_refused();
        oem2_lock = 1'b0;
        inject(1'b1, oem2_key, 1'b1);
        check("R6 eval busy", busy, 1'b1);
        tick();
        check("R6 lock2 clear level", level, 2'd2);
        check("R6 lock2 clear err", key_err, 1'b1);
        tick();
        check("R13 err sticky", key_err, 1'b1);
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        check("R13 err cleared", key_err, 1'b0);
        oem2_lock = 1'b1;
        inject(1'b1, oem2_key ^ 128'h1, 1'b1);
        tick();
        check("R6 wrong key byte", ob_value, 8'hCC);
        check("R6 wrong key err", key_err, 1'b1);
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        inject(1'b1, oem2_key, 1'b0);
        check("R7 no phase busy", busy, 1'b0);
        tick();
        check("R7 no phase byte", ob_value, 8'hCC);
        check("R7 no phase err", key_err, 1'b0);
    endtask

    task automatic t_key2_grant();
        inject(1'b1, oem2_key, 1'b1);
        tick();
        check("R5 l2 grant byte", ob_value, 8'h55);
        check("R5 l2 grant level", level, 2'd1);
        check("R5 no erase", erase_req, 1'b0);
        check("R5 no err", key_err, 1'b0);
    endtask

    task automatic t_key1_erase();
        oem1_lock = 1'b1;
        sw_write(8'hAA);
        check("R8 lock1 set write AA", ob_value, 8'h55);
        check("R8 lock1 set no erase", erase_req, 1'b0);
        inject(1'b0, oem1_key, 1'b1);
        tick();
        check("R7 erase_req", erase_req, 1'b1);
        check("R7 still level1", level, 2'd1);
        sw_write(8'hCC);
        check("R9 write while busy", ob_value, 8'h55);
        inject(1'b1, oem2_key, 1'b1);
        tick(); tick();
        check("R9 erase held", erase_req, 1'b1);
        check("R9 busy held", busy, 1'b1);
        erase_done = 1'b1; tick(); erase_done = 1'b0;
        check("R9 open after done", ob_value, 8'hAA);
        check("R9 busy drop", busy, 1'b0);
        check("R9 erase drop", erase_req, 1'b0);
        erase_done = 1'b1; tick(); erase_done = 1'b0;
        check("R9 stray done", ob_value, 8'hAA);
        oem1_lock = 1'b0;
    endtask

    task automatic t_sw_regress();
        do_reset();
        sw_write(8'h42);
        inject(1'b0, oem1_key, 1'b1);
        tick();
        check("R6 lock1 clear key err", key_err, 1'b1);
        check("R6 lock1 clear no erase", erase_req, 1'b0);
        sw_write(8'hAA);
        check("R8 sw erase", erase_req, 1'b1);
        check("R8 level waits", level, 2'd1);
        erase_done = 1'b1; tick(); erase_done = 1'b0;
        check("R8 sw open", level, 2'd0);
        sw_write(8'hCC);
        check("R2 open to closed", level, 2'd2);
    endtask

    initial begin
        t_reset();
        t_open_writes();
        t_closed_locked();
        t_key2_refused();
        t_key2_grant();
        t_key1_erase();
        t_sw_regress();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule